// File: doc/BRIEF.md
# Quarter-Wave Numerically Controlled Oscillator

This block is a local-oscillator source for a digital mixer. A wide phase register steps once per sample clock by a programmable step word. The running phase plus a separate offset word is cut down to its most significant bits. Those bits address a sine table that stores only the first quarter of a cycle. The other three quarters come from mirroring the table address and negating the result. A second look-up, a quarter cycle ahead, gives the cosine. Both outputs are signed 16-bit samples.

The output frequency is the step word times the sample rate divided by 2^32. The step word is captured in a register. A new value changes the rate at which the phase advances but never resets the phase, so a frequency hop leaves no break in the waveform. The offset word shifts only the table address and leaves the running phase unchanged. While the enable input is low, the phase does not advance.

Top module: `nco_quarter_wave`

## Requirements
- R1: A synchronous, active-high reset clears the phase register, the captured step word and both outputs to 0. With a step word of 0 after reset, the outputs show table index 0.
- R2: On each clock edge with enable high, the phase register increases by the captured step word. The output frequency is therefore step × fS / 2^32.
- R3: The phase register is 32 bits wide and wraps modulo 2^32 with no saturation.
- R4: The table index is bits 31..20 of (phase + offset) mod 2^32. Bits 19..0 of that sum have no effect on the outputs.
- R5: The sine output for index p (0..4095) is round(32767 · sin(2π(p+0.5)/4096)), rounded half away from zero, as a two's-complement 16-bit value.
- R6: The cosine output for index p equals the sine value for index (p+1024) mod 4096.
- R7: The index bits 11..10 select the quadrant. Quadrants 1 and 3 mirror the address by inverting bits 9..0, and quadrants 2 and 3 negate the value. As a result, sample(p+2048) = −sample(p) and sample(2047−p) = sample(p).
- R8: The step word is registered and first applies at the edge after the one that captures it. A change of step word does not alter the current phase.
- R9: The offset word is added after the phase register and never alters the stored phase. Removing the offset returns the outputs to the un-shifted phase track.
- R10: While enable is low, the phase register holds its value.
- R11: The outputs reflect the phase and offset present two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable for the phase register |
| tune_word | input | 32 | Phase step per sample, captured every clock |
| phase_ofs | input | 32 | Phase offset added ahead of the table look-up |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |

## Verification
The assertions assume that every input is stable at each rising edge and that reset is held for at least one edge before checking starts. They also rely on the table holding only strictly positive quarter-wave magnitudes, which makes the sign of each output follow from its quadrant alone. The bench changes inputs only on falling edges and always asserts reset before each scenario. Its step and offset words span the full 32-bit range, including values that force the phase to wrap and offsets that land exactly on quadrant edges.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Quadrant named by its two top index bits.
  typedef enum logic [1:0] {
    QUAD_RISE    = 2'd0,
    QUAD_FALL    = 2'd1,
    QUAD_DIP     = 2'd2,
    QUAD_RETURN  = 2'd3
  } quad_e;

  localparam real NCO_TWO_PI = 6.283185307179586;

  // Round to nearest, ties away from zero.
  function automatic int round_away(input real x);
    if (x < 0.0) return -$rtoi(-x + 0.5);
    return $rtoi(x + 0.5);
  endfunction

  // Quadrants 1 and 3 read the table backwards.
  function automatic logic quad_mirrors(input quad_e q);
    return (q == QUAD_FALL) || (q == QUAD_RETURN);
  endfunction

  // Quadrants 2 and 3 lie below zero.
  function automatic logic quad_negates(input quad_e q);
    return (q == QUAD_DIP) || (q == QUAD_RETURN);
  endfunction

endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] step_in,
  output logic [ACC_W-1:0] step_held,
  output logic [ACC_W-1:0] phase_q
);

  // The step word is captured first, so a new value acts one edge later.
  always_ff @(posedge clk) begin
    if (rst) begin
      step_held <= '0;
      phase_q   <= '0;
    end else begin
      step_held <= step_in;
      if (en) phase_q <= phase_q + step_held;   // wraps modulo 2^ACC_W
    end
  end

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int IDX_W = 12,
  parameter int AMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        idx,
  output logic signed [AMP_W-1:0] sample
);
  import nco_pkg::*;

  localparam int QA_W   = IDX_W - 2;
  localparam int QDEPTH = 1 << QA_W;
  localparam int FULL   = 1 << IDX_W;
  localparam real PEAK  = real'((1 << (AMP_W - 1)) - 1);

  typedef logic signed [AMP_W-1:0] tbl_t [QDEPTH];

  // Mid-point sampling keeps the mirrored quadrants exactly symmetric.
  function automatic tbl_t build_table();
    tbl_t t;
    real  a;
    for (int k = 0; k < QDEPTH; k++) begin
      a    = PEAK * $sin(NCO_TWO_PI * (real'(k) + 0.5) / real'(FULL));
      t[k] = AMP_W'(round_away(a));
    end
    return t;
  endfunction

  localparam tbl_t QTABLE = build_table();

  quad_e                   quad;
  logic [QA_W-1:0]         addr;
  logic signed [AMP_W-1:0] mag;

  always_comb begin
    quad = quad_e'(idx[IDX_W-1 -: 2]);
    addr = quad_mirrors(quad) ? ~idx[QA_W-1:0] : idx[QA_W-1:0];
    mag  = QTABLE[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= quad_negates(quad) ? -mag : mag;
  end

endmodule

// File: rtl/nco_quarter_wave.sv
module nco_quarter_wave #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 12,
  parameter int AMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic [ACC_W-1:0]        phase_ofs,
  output logic signed [AMP_W-1:0] sin_out,
  output logic signed [AMP_W-1:0] cos_out
);

  localparam int DROP_W  = ACC_W - IDX_W;
  localparam int QUARTER = 1 << (IDX_W - 2);
  localparam int NCH     = 2;   // 0: sine, 1: cosine

  logic [ACC_W-1:0] ftw_held;
  logic [ACC_W-1:0] acc_cur;
  logic [IDX_W-1:0] lut_next;
  logic [IDX_W-1:0] lut_idx;
  logic signed [AMP_W-1:0] ch_sample [NCH];

  nco_phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .step_in  (tune_word),
    .step_held(ftw_held),
    .phase_q  (acc_cur)
  );

  // Offset is applied after the accumulator; the stored phase is untouched.
  assign lut_next = IDX_W'((acc_cur + phase_ofs) >> DROP_W);

  always_ff @(posedge clk) begin
    if (rst) lut_idx <= '0;
    else     lut_idx <= lut_next;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [IDX_W-1:0] ch_idx;
    assign ch_idx = lut_idx + IDX_W'(g * QUARTER);
    nco_quarter_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
      .clk   (clk),
      .rst   (rst),
      .idx   (ch_idx),
      .sample(ch_sample[g])
    );
  end

  assign sin_out = ch_sample[0];
  assign cos_out = ch_sample[1];

endmodule

// File: rtl/nco_quarter_wave_chk.sv
module nco_quarter_wave_chk #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 12,
  parameter int AMP_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        tune_word,
  input logic [ACC_W-1:0]        ftw_held,
  input logic [ACC_W-1:0]        acc_cur,
  input logic [IDX_W-1:0]        lut_idx,
  input logic signed [AMP_W-1:0] sin_out,
  input logic signed [AMP_W-1:0] cos_out
);

  assert_step_capture_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ftw_held == $past(tune_word));

  assert_acc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> acc_cur == $past(acc_cur) + $past(ftw_held));

  assert_acc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_cur));

  assert_sin_sign_R7: assert property (@(posedge clk) disable iff (rst)
    lut_idx[IDX_W-1] |=> sin_out < 0);

  assert_sin_pos_R7: assert property (@(posedge clk) disable iff (rst)
    !lut_idx[IDX_W-1] |=> sin_out > 0);

  assert_cos_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (lut_idx[IDX_W-1] ^ lut_idx[IDX_W-2]) |=> cos_out < 0);

  assert_no_min_code_R5: assert property (@(posedge clk) disable iff (rst)
    sin_out != {1'b1, {(AMP_W-1){1'b0}}} && cos_out != {1'b1, {(AMP_W-1){1'b0}}});

endmodule

bind nco_quarter_wave nco_quarter_wave_chk #(
  .ACC_W(ACC_W), .IDX_W(IDX_W), .AMP_W(AMP_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .tune_word(tune_word),
  .ftw_held (ftw_held),
  .acc_cur  (acc_cur),
  .lut_idx  (lut_idx),
  .sin_out  (sin_out),
  .cos_out  (cos_out)
);

// File: tb/nco_quarter_wave_test.sv
`timescale 1ns/1ps
module nco_quarter_wave_test;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en  = 1'b0;
  logic [31:0]        tune_word = '0;
  logic [31:0]        phase_ofs = '0;
  logic signed [15:0] sin_out;
  logic signed [15:0] cos_out;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  nco_quarter_wave uut (
    .clk(clk), .rst(rst), .en(en),
    .tune_word(tune_word), .phase_ofs(phase_ofs),
    .sin_out(sin_out), .cos_out(cos_out)
  );

  // Reference of the requirement-level behaviour: phase track and delay line.
  logic [31:0] m_step = '0;
  logic [31:0] m_phase = '0;
  logic [11:0] m_d1 = '0;
  logic [11:0] m_d2 = '0;
  logic        m_valid = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_step <= '0; m_phase <= '0; m_d1 <= '0; m_d2 <= '0; m_valid <= 1'b0;
    end else begin
      m_step <= tune_word;
      if (en) m_phase <= m_phase + m_step;
      m_d1    <= 12'((m_phase + phase_ofs) / 32'h0010_0000);
      m_d2    <= m_d1;
      m_valid <= 1'b1;
    end
  end

  // Full-cycle sine evaluated directly, no folding.
  function automatic int ref_sample(input int p);
    real x;
    x = 32767.0 * $sin(6.283185307179586 * (real'(p % 4096) + 0.5) / 4096.0);
    if (x < 0.0) return -$rtoi(-x + 0.5);
    return $rtoi(x + 0.5);
  endfunction

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_model(input string req);
    expect_eq(req, "sin", int'(sin_out), ref_sample(int'(m_d2)));
    expect_eq(req, "cos", int'(cos_out), ref_sample(int'(m_d2) + 1024));
  endtask

  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; tune_word = '0; phase_ofs = '0;
    step_cycle();
    step_cycle();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rst = 1'b1;
    step_cycle();
    expect_eq("R1", "sin in reset", int'(sin_out), 0);
    expect_eq("R1", "cos in reset", int'(cos_out), 0);
    rst = 1'b0;
    step_cycle();
    step_cycle();
    expect_eq("R1", "sin idx0", int'(sin_out), ref_sample(0));
    expect_eq("R1", "cos idx0", int'(cos_out), ref_sample(1024));
  endtask

  task automatic t_run(input string req, input logic [31:0] step, input int n);
    tune_word = step; en = 1'b1;
    for (int i = 0; i < n; i++) begin
      step_cycle();
      if (m_valid) check_model(req);
    end
  endtask

  task automatic t_latency();
    // R11: offset change appears on the outputs exactly two edges later.
    do_reset();
    step_cycle(); step_cycle();
    phase_ofs = 32'h4000_0000;
    step_cycle();
    expect_eq("R11", "one edge", int'(sin_out), ref_sample(0));
    step_cycle();
    expect_eq("R11", "two edges", int'(sin_out), ref_sample(1024));
    // R8: step word captured at edge 1 advances phase only at edge 2.
    do_reset();
    tune_word = 32'h0100_0000; en = 1'b1;
    step_cycle(); step_cycle(); step_cycle();
    expect_eq("R8", "first step not yet visible", int'(sin_out), ref_sample(0));
    step_cycle();
    expect_eq("R8", "first step visible", int'(sin_out), ref_sample(16));
  endtask

  task automatic t_quadrants();
    int pts[8] = '{0, 1023, 1024, 2047, 2048, 3071, 3072, 4095};
    do_reset();
    foreach (pts[i]) begin
      phase_ofs = 32'(pts[i]) << 20;
      step_cycle(); step_cycle();
      check_model("R7");
      expect_eq("R5", "direct index", int'(sin_out), ref_sample(pts[i]));
      // R4: the discarded low bits cannot move the index.
      phase_ofs = (32'(pts[i]) << 20) | 32'h000F_FFFF;
      step_cycle(); step_cycle();
      expect_eq("R4", "low bits ignored", int'(sin_out), ref_sample(pts[i]));
    end
    expect_eq("R7", "half-cycle negation", ref_sample(2048 + 300), -ref_sample(300));
    expect_eq("R7", "mirror", ref_sample(2047 - 300), ref_sample(300));
  endtask

  task automatic t_enable();
    logic signed [15:0] held_s;
    do_reset();
    t_run("R2", 32'h0123_4567, 20);
    en = 1'b0;
    step_cycle(); step_cycle();
    held_s = sin_out;
    for (int i = 0; i < 8; i++) begin
      step_cycle();
      expect_eq("R10", "hold", int'(sin_out), int'(held_s));
    end
    check_model("R10");
  endtask

  task automatic t_offset_restore();
    do_reset();
    t_run("R9", 32'h0077_0000, 10);
    phase_ofs = 32'hA5A5_0000;
    t_run("R9", 32'h0077_0000, 6);
    phase_ofs = '0;
    t_run("R9", 32'h0077_0000, 6);
  endtask

  initial begin
    t_reset();
    do_reset();
    t_run("R2", 32'h0123_4567, 40);
    t_run("R8", 32'h0A00_0000, 30);      // hop without phase reset
    t_run("R3", 32'hF000_0001, 40);      // forces repeated wraps
    t_run("R6", 32'h4000_0000, 8);
    t_latency();
    t_quadrants();
    t_enable();
    t_offset_restore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule